// File: doc/BRIEF.md
# Hysteresis-Based RTS/CTS Hardware Flow Controller

This block handles automatic hardware handshaking for a single serial channel. On the receive side it watches the fill level of the receive FIFO and drives the RTS line. RTS goes inactive (high) once the level climbs to a programmable halt level. It goes active (low) again only after the level has drained to a separate, lower resume level. The gap between the two levels acts as a hysteresis band, so the far end is not toggled on and off around a single trigger point.

On the transmit side the block resynchronizes the incoming CTS line. While that line is high and CTS control is enabled, it refuses new character starts. A character that has already been granted is never cut off, because only start requests pass through the gate.

Each of the two lines has a sticky flag. The flag is set when the line goes from active to inactive, and the interrupt logic clears it with an acknowledge pulse. The FIFO itself, the baud timing and any in-band software handshaking are handled elsewhere.

Top module: `uart_hw_flow_ctrl`

## Requirements
- R1: After reset `rts_n_o` is 0, both flags are 0, and the thresholds hold halt field 15 and resume field 0 (levels 60 and 0).
- R2: With `rts_auto_en_i` high, `rts_n_o` is 1 from the clock edge after the one at which `rx_level_i` is at least 4 times the halt field. The halt field is bits [3:0] of the threshold byte.
- R3: With `rts_auto_en_i` high, `rts_n_o` returns to 0 after the edge at which `rx_level_i` is at most 4 times the resume field (bits [7:4]) and below the halt level. Between the two levels it keeps its value. When both conditions hold, halting wins.
- R4: With `rts_auto_en_i` low, `rts_n_o` is 0 from the following edge on, whatever the level.
- R5: `tx_start_ok_o` equals `tx_start_req_i`, except that it is 0 while `cts_auto_en_i` is high and the synchronized CTS is high. The gate is combinational on the request, so only new starts are blocked.
- R6: A level change on `cts_n_i` reaches the synchronized CTS, and with it the gate, after exactly two rising clock edges.
- R7: `rts_deassert_flag_o` becomes 1 at the same edge where `rts_n_o` goes from 0 to 1. It stays set until acknowledged.
- R8: `cts_deassert_flag_o` becomes 1 at the same edge where the synchronized CTS goes from 0 to 1. This holds whether or not CTS control is enabled. The flag stays set until acknowledged.
- R9: A `flag_ack_i` pulse clears both flags at the next edge. A flag that is being set at that same edge stays 1.
- R10: A write through `thr_wr_i` updates the threshold byte only while `feat_unlock_i` is high. Otherwise the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_unlock_i | input | 1 | Write permission for the threshold byte |
| rts_auto_en_i | input | 1 | Enable automatic RTS control |
| cts_auto_en_i | input | 1 | Enable CTS gating of transmit starts |
| thr_wr_i | input | 1 | Threshold byte write strobe |
| thr_wdata_i | input | 8 | Threshold byte: [3:0] halt field, [7:4] resume field |
| rx_level_i | input | LEVEL_W (7) | Current receive FIFO fill level in bytes |
| cts_n_i | input | 1 | CTS line from the far end, active low, asynchronous |
| tx_start_req_i | input | 1 | Transmitter asks to begin a character |
| flag_ack_i | input | 1 | Clears both deassert flags |
| tx_start_ok_o | output | 1 | Permission to begin the requested character |
| rts_n_o | output | 1 | RTS line, active low |
| rts_deassert_flag_o | output | 1 | Sticky: RTS went inactive |
| cts_deassert_flag_o | output | 1 | Sticky: synchronized CTS went inactive |

## Verification
The receive level is driven through a slow ramp up and down across the hysteresis band. This shows whether RTS latches and holds inside the band instead of following a single compare. A pair of thresholds with the resume level above the halt level tells apart the two possible orders of priority. A write with the unlock low, followed by a ramp, reveals whether the threshold byte was changed. CTS is toggled with gating on and off while requests are held, and a long random phase mixes every input to catch interactions between acknowledge and flag setting.

// File: rtl/hwfc_pkg.sv
package hwfc_pkg;

    localparam int FIELD_W  = 4;
    localparam int SCALE_SH = 2;
    localparam int SCALED_W = FIELD_W + SCALE_SH;

    typedef struct packed {
        logic [FIELD_W-1:0] resume;
        logic [FIELD_W-1:0] halt;
    } fc_thr_t;

    localparam fc_thr_t THR_RESET = '{resume: 4'h0, halt: 4'hF};

    typedef enum logic {
        RTS_ASSERTED   = 1'b0,
        RTS_DEASSERTED = 1'b1
    } rts_state_e;

    function automatic logic [SCALED_W-1:0] fc_scale(input logic [FIELD_W-1:0] f);
        return {f, {SCALE_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/fc_thr_reg.sv
module fc_thr_reg
    import hwfc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    unlock,
    input  logic    wr,
    input  fc_thr_t wdata,
    output fc_thr_t thr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr <= THR_RESET;
        end else if (wr && unlock) begin
            thr <= wdata;
        end
    end

    assert_locked_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && !unlock) |=> $stable(thr));

endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
    import hwfc_pkg::*;
#(
    parameter int LEVEL_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  fc_thr_t            thr,
    input  logic [LEVEL_W-1:0] level,
    output logic               rts_n,
    output logic               rts_rise
);

    localparam int CMP_W = (LEVEL_W > SCALED_W) ? LEVEL_W : SCALED_W;

    logic [CMP_W-1:0] lvl_x, halt_x, resume_x;
    rts_state_e       state_q, state_d;

    assign lvl_x    = CMP_W'(level);
    assign halt_x   = CMP_W'(fc_scale(thr.halt));
    assign resume_x = CMP_W'(fc_scale(thr.resume));

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = RTS_ASSERTED;
        end else if (lvl_x >= halt_x) begin
            state_d = RTS_DEASSERTED;
        end else if (lvl_x <= resume_x) begin
            state_d = RTS_ASSERTED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RTS_ASSERTED;
        end else begin
            state_q <= state_d;
        end
    end

    assign rts_n    = (state_q == RTS_DEASSERTED);
    assign rts_rise = (state_d == RTS_DEASSERTED) && (state_q == RTS_ASSERTED);

    assert_halt_reached_R2: assert property (@(posedge clk) disable iff (rst)
        (enable && lvl_x >= halt_x) |=> rts_n);

    assert_resume_reached_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && lvl_x <= resume_x && lvl_x < halt_x) |=> !rts_n);

    assert_band_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && lvl_x > resume_x && lvl_x < halt_x) |=> $stable(rts_n));

    assert_disabled_low_R4: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !rts_n);

endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cts_n_pin,
    input  logic start_req,
    output logic start_ok,
    output logic cts_rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cts_hi;

    generate
        if (SYNC_STAGES < 2) begin : g_bad_depth
            initial $error("fc_cts_gate needs at least two synchronizer stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n_pin};
        end
    end

    assign cts_hi   = sync_q[SYNC_STAGES-1];
    assign cts_rise = sync_q[SYNC_STAGES-2] && !cts_hi;
    assign start_ok = start_req && !(enable && cts_hi);

    assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && cts_hi) |-> !start_ok);

    assert_no_spurious_start_R5: assert property (@(posedge clk) disable iff (rst)
        start_ok |-> start_req);

    assert_rise_lands_R6: assert property (@(posedge clk) disable iff (rst)
        cts_rise |=> cts_hi);

endmodule

// File: rtl/fc_sticky_flag.sv
module fc_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && !set) |=> !flag);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

endmodule

// File: rtl/uart_hw_flow_ctrl.sv
module uart_hw_flow_ctrl
    import hwfc_pkg::*;
#(
    parameter int LEVEL_W     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               feat_unlock_i,
    input  logic               rts_auto_en_i,
    input  logic               cts_auto_en_i,
    input  logic               thr_wr_i,
    input  logic [7:0]         thr_wdata_i,
    input  logic [LEVEL_W-1:0] rx_level_i,
    input  logic               cts_n_i,
    input  logic               tx_start_req_i,
    input  logic               flag_ack_i,
    output logic               tx_start_ok_o,
    output logic               rts_n_o,
    output logic               rts_deassert_flag_o,
    output logic               cts_deassert_flag_o
);

    fc_thr_t thr;
    logic    rts_rise, cts_rise;

    fc_thr_reg u_thr (
        .clk    (clk),
        .rst    (rst),
        .unlock (feat_unlock_i),
        .wr     (thr_wr_i),
        .wdata  (fc_thr_t'(thr_wdata_i)),
        .thr    (thr)
    );

    fc_rts_ctrl #(.LEVEL_W(LEVEL_W)) u_rts (
        .clk      (clk),
        .rst      (rst),
        .enable   (rts_auto_en_i),
        .thr      (thr),
        .level    (rx_level_i),
        .rts_n    (rts_n_o),
        .rts_rise (rts_rise)
    );

    fc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk       (clk),
        .rst       (rst),
        .enable    (cts_auto_en_i),
        .cts_n_pin (cts_n_i),
        .start_req (tx_start_req_i),
        .start_ok  (tx_start_ok_o),
        .cts_rise  (cts_rise)
    );

    fc_sticky_flag u_rts_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (rts_rise),
        .ack  (flag_ack_i),
        .flag (rts_deassert_flag_o)
    );

    fc_sticky_flag u_cts_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (cts_rise),
        .ack  (flag_ack_i),
        .flag (cts_deassert_flag_o)
    );

    assert_rts_edge_flag_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_n_o) |-> rts_deassert_flag_o);

endmodule

// File: tb/uart_hw_flow_ctrl_tb_top.sv
module uart_hw_flow_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LEVEL_W    = 7;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               feat_unlock_i = 1'b0;
    logic               rts_auto_en_i = 1'b0;
    logic               cts_auto_en_i = 1'b0;
    logic               thr_wr_i = 1'b0;
    logic [7:0]         thr_wdata_i = '0;
    logic [LEVEL_W-1:0] rx_level_i = '0;
    logic               cts_n_i = 1'b0;
    logic               tx_start_req_i = 1'b0;
    logic               flag_ack_i = 1'b0;
    logic               tx_start_ok_o;
    logic               rts_n_o;
    logic               rts_deassert_flag_o;
    logic               cts_deassert_flag_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference state
    int m_halt, m_resume, m_rts, m_s1, m_s2, m_rf, m_cf;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_hw_flow_ctrl #(.LEVEL_W(LEVEL_W)) dut_i (
        .clk                 (clk),
        .rst                 (rst),
        .feat_unlock_i       (feat_unlock_i),
        .rts_auto_en_i       (rts_auto_en_i),
        .cts_auto_en_i       (cts_auto_en_i),
        .thr_wr_i            (thr_wr_i),
        .thr_wdata_i         (thr_wdata_i),
        .rx_level_i          (rx_level_i),
        .cts_n_i             (cts_n_i),
        .tx_start_req_i      (tx_start_req_i),
        .flag_ack_i          (flag_ack_i),
        .tx_start_ok_o       (tx_start_ok_o),
        .rts_n_o             (rts_n_o),
        .rts_deassert_flag_o (rts_deassert_flag_o),
        .cts_deassert_flag_o (cts_deassert_flag_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int lvl, nxt, rts_up, cts_up;
        if (rst) begin
            m_halt = 15; m_resume = 0; m_rts = 0;
            m_s1 = 0; m_s2 = 0; m_rf = 0; m_cf = 0;
        end else begin
            lvl = int'(rx_level_i);
            if (!rts_auto_en_i)            nxt = 0;
            else if (lvl >= m_halt * 4)    nxt = 1;
            else if (lvl <= m_resume * 4)  nxt = 0;
            else                           nxt = m_rts;
            rts_up = (nxt == 1 && m_rts == 0) ? 1 : 0;
            cts_up = (m_s1 == 1 && m_s2 == 0) ? 1 : 0;
            m_rf = rts_up ? 1 : (flag_ack_i ? 0 : m_rf);
            m_cf = cts_up ? 1 : (flag_ack_i ? 0 : m_cf);
            m_rts = nxt;
            m_s2 = m_s1;
            m_s1 = int'(cts_n_i);
            if (thr_wr_i && feat_unlock_i) begin
                m_halt   = int'(thr_wdata_i[3:0]);
                m_resume = int'(thr_wdata_i[7:4]);
            end
        end
    end

    // compare against the model every cycle, mid-period
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 R3 R4 rts", int'(rts_n_o), m_rts);
            chk("R7 R9 rts flag", int'(rts_deassert_flag_o), m_rf);
            chk("R8 R9 cts flag", int'(cts_deassert_flag_o), m_cf);
            chk("R5 R6 tx gate", int'(tx_start_ok_o),
                (tx_start_req_i && !(cts_auto_en_i && m_s2 == 1)) ? 1 : 0);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_thr(input logic [7:0] v, input logic unl);
        thr_wdata_i = v; feat_unlock_i = unl; thr_wr_i = 1'b1;
        step();
        thr_wr_i = 1'b0; feat_unlock_i = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk("R1 rts after reset", int'(rts_n_o), 0);
        chk("R1 rts flag after reset", int'(rts_deassert_flag_o), 0);
        chk("R1 cts flag after reset", int'(cts_deassert_flag_o), 0);
        step();
        // R1 reset thresholds: halt at 60
        rts_auto_en_i = 1'b1;
        rx_level_i = 7'd59; step(2);
        chk("R1 level 59 below reset halt", int'(rts_n_o), 0);
        rx_level_i = 7'd60; step();
        #2 chk("R1 reset halt 60", int'(rts_n_o), 1);
        rx_level_i = 7'd0; step(2);

        // R10: halt=3 (12), resume=1 (4) with unlock
        write_thr(8'h13, 1'b1);
        for (int l = 0; l <= 20; l++) begin rx_level_i = LEVEL_W'(l); step(); end
        #2 chk("R2 above halt", int'(rts_n_o), 1);
        for (int l = 20; l >= 0; l--) begin rx_level_i = LEVEL_W'(l); step(); end
        #2 chk("R3 drained", int'(rts_n_o), 0);
        flag_ack_i = 1'b1; step(); flag_ack_i = 1'b0;

        // R10: locked write must not change halt 12
        write_thr(8'h0F, 1'b0);
        rx_level_i = 7'd12; step();
        #2 chk("R10 locked write ignored", int'(rts_n_o), 1);
        rx_level_i = 7'd8; step(2);
        #2 chk("R3 inside band holds", int'(rts_n_o), 1);
        rx_level_i = 7'd4; step();

        // R3 overlap: halt=2 (8), resume=5 (20): halt wins
        write_thr(8'h52, 1'b1);
        rx_level_i = 7'd10; step();
        #2 chk("R3 overlap halt wins", int'(rts_n_o), 1);
        rx_level_i = 7'd5; step();
        #2 chk("R3 overlap resume", int'(rts_n_o), 0);

        // R4 disable while halted; R9 ack coinciding with set
        rx_level_i = 7'd30; flag_ack_i = 1'b1; step(); flag_ack_i = 1'b0;
        #2 chk("R9 set wins over ack", int'(rts_deassert_flag_o), 1);
        rts_auto_en_i = 1'b0; step();
        #2 chk("R4 disabled forces low", int'(rts_n_o), 0);
        step(3);
        rts_auto_en_i = 1'b1;

        // R5/R6 CTS gating
        tx_start_req_i = 1'b1; cts_auto_en_i = 1'b1;
        cts_n_i = 1'b1; step();
        #2 chk("R6 one edge not yet", int'(tx_start_ok_o), 1);
        step();
        #2 chk("R6 two edges gate", int'(tx_start_ok_o), 0);
        chk("R8 cts flag", int'(cts_deassert_flag_o), 1);
        cts_auto_en_i = 1'b0; #1;
        chk("R5 gating off", int'(tx_start_ok_o), 1);
        flag_ack_i = 1'b1; step(); flag_ack_i = 1'b0;
        #2 chk("R9 ack clears", int'(cts_deassert_flag_o), 0);
        cts_n_i = 1'b0; step(3);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            rts_auto_en_i  = ($urandom % 8) != 0;
            cts_auto_en_i  = ($urandom % 4) != 0;
            tx_start_req_i = $urandom % 2;
            cts_n_i        = ($urandom % 5) == 0 ? ~cts_n_i : cts_n_i;
            flag_ack_i     = ($urandom % 6) == 0;
            feat_unlock_i  = $urandom % 2;
            thr_wr_i       = ($urandom % 40) == 0;
            thr_wdata_i    = 8'($urandom);
            rx_level_i     = LEVEL_W'($urandom % 65);
            step();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule